// File: doc/BRIEF.md
# Sensor Heater Contrast Controller

This block drives the enable of the on-die heater of a thermal swipe sensor. Each frame carries a 4-bit relative temperature code, where 8 means no change, one step near the middle is about 1.4 K, and the end codes 0 and 15 are saturated bounds rather than values. When the host sees faint image contrast it raises a request. The controller then latches the present code as a baseline and switches the heater on. It switches it off once the code has climbed by a configured number of steps (normally two), once a saturated high code shows up, or once a cycle budget runs out.

The heater is meant to be on only briefly, because heating the die takes on the order of seconds. After every heating period the controller ignores new requests for a configured number of frames. A nap request overrides everything and keeps the heater off. A timeout exit sets a sticky fault flag, which only a reset clears.

Top module: `heater_ctl`

## Requirements
- R1: While reset is asserted and after it is released, `heat_en` is 0, `ctl_state` is 0 (idle), `timeout_fault` is 0 and `base_code` is 8.
- R2: In idle, a high `low_contrast` latches a baseline and moves to heating (`ctl_state` 1) at the next edge, with `heat_en` high. The baseline is the code on the same cycle when `code_vld` is high, and otherwise the most recent valid code. It appears on `base_code`.
- R3: While heating, the first valid code that is greater than or equal to the target ends heating at that edge and moves to hold-off (`ctl_state` 2). The target is baseline plus `cfg_step`.
- R4: With no ending code, `heat_en` stays high for exactly `cfg_timeout`+1 cycles and then moves to hold-off.
- R5: A timeout exit sets `timeout_fault`. The flag then stays set until reset. An exit on a code does not set it.
- R6: The target is limited to 14. A baseline of 13 with a step of 2 ends heating on code 14.
- R7: A valid code of 15 while heating ends heating at once.
- R8: Hold-off counts valid codes. It returns to idle on the edge after `cfg_holdoff` of them have been counted, or after one cycle when `cfg_holdoff` is 0. Requests are ignored during hold-off.
- R9: A high `nap_req` moves any state to nap (`ctl_state` 3) at the next edge, with `heat_en` low. Nap is held while `nap_req` stays high, and the block returns to idle when it drops.
- R10: A request whose baseline would be the saturated code 15 is ignored, and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_vld | input | 1 | Strobe: one temperature code per frame |
| code | input | 4 | Relative temperature code, 8 = no change |
| low_contrast | input | 1 | Host request to heat |
| nap_req | input | 1 | Nap mode, forces the heater off |
| cfg_step | input | 4 | Code steps to gain above the baseline |
| cfg_timeout | input | TMO_W | Heating cycle budget |
| cfg_holdoff | input | HOLD_W | Frames to block requests after heating |
| heat_en | output | 1 | Heater enable |
| ctl_state | output | 2 | 0 idle, 1 heating, 2 hold-off, 3 nap |
| timeout_fault | output | 1 | Sticky: heating ended by timeout |
| base_code | output | 4 | Latched baseline code |

## Verification
The embedded properties check on every cycle the rules that relate ports across one edge: nap forces the heater off, code 15 stops heating, heating starts only after a request, the fault flag never clears, and the target never exceeds 14. Other behaviours depend on the sequence of frames and are shown only by the bench scenarios. These are the exact heating length on timeout, the baseline choice between the same-cycle code and the held code, the clamp at 14, the frame count in hold-off (including zero), and a saturated baseline being refused.

// File: rtl/htr_pkg.sv
`timescale 1ns/1ps
package htr_pkg;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_ZERO   = 4'd8;
  localparam logic [CODE_W-1:0] CODE_SAT_HI = 4'd15;
  localparam logic [CODE_W-1:0] CODE_CAP    = 4'd14;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HEAT = 2'd1,
    ST_HOLD = 2'd2,
    ST_NAP  = 2'd3
  } htr_state_e;
endpackage

// File: rtl/htr_rst_sync.sv
`timescale 1ns/1ps
module htr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sn = sync_q;
endmodule

// File: rtl/htr_target.sv
`timescale 1ns/1ps
module htr_target
  import htr_pkg::*;
(
  input  logic [CODE_W-1:0] base,
  input  logic [CODE_W-1:0] step,
  output logic [CODE_W-1:0] tgt
);
  logic [CODE_W:0] sum;

  always_comb begin
    sum = {1'b0, base} + {1'b0, step};
    if (sum > {1'b0, CODE_CAP}) tgt = CODE_CAP;
    else                        tgt = sum[CODE_W-1:0];
  end
endmodule

// File: rtl/htr_count.sv
`timescale 1ns/1ps
module htr_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign hit = (cnt_q >= limit);

  always_comb begin
    cnt_en = clr | (inc & ~hit);
    cnt_d  = clr ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/heater_ctl.sv
`timescale 1ns/1ps
module heater_ctl
  import htr_pkg::*;
#(
  parameter int TMO_W  = 24,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_vld,
  input  logic [3:0]        code,
  input  logic              low_contrast,
  input  logic              nap_req,
  input  logic [3:0]        cfg_step,
  input  logic [TMO_W-1:0]  cfg_timeout,
  input  logic [HOLD_W-1:0] cfg_holdoff,
  output logic              heat_en,
  output logic [1:0]        ctl_state,
  output logic              timeout_fault,
  output logic [3:0]        base_code
);
  logic rst_sn;

  htr_state_e state_q, state_d;
  logic [CODE_W-1:0] last_q, base_q, base_in, tgt;
  logic fault_q;
  logic last_ld, base_ld, fault_set;
  logic heat_hit, hold_hit;
  logic code_done;

  htr_rst_sync i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  htr_target i_target (
    .base (base_q),
    .step (cfg_step),
    .tgt  (tgt)
  );

  htr_count #(.W(TMO_W)) i_heat_cnt (
    .clk   (clk),
    .rst_n (rst_sn),
    .clr   (state_q != ST_HEAT),
    .inc   (1'b1),
    .limit (cfg_timeout),
    .hit   (heat_hit)
  );

  htr_count #(.W(HOLD_W)) i_hold_cnt (
    .clk   (clk),
    .rst_n (rst_sn),
    .clr   (state_q != ST_HOLD),
    .inc   (code_vld),
    .limit (cfg_holdoff),
    .hit   (hold_hit)
  );

  // next-state and clock enables
  always_comb begin
    base_in   = code_vld ? code : last_q;
    code_done = code_vld & ((code == CODE_SAT_HI) | (code >= tgt));
    state_d   = state_q;
    fault_set = 1'b0;
    unique case (state_q)
      ST_IDLE: if (low_contrast && (base_in != CODE_SAT_HI)) state_d = ST_HEAT;
      ST_HEAT: begin
        if (code_done) begin
          state_d = ST_HOLD;
        end else if (heat_hit) begin
          state_d   = ST_HOLD;
          fault_set = ~nap_req;
        end
      end
      ST_HOLD: if (hold_hit) state_d = ST_IDLE;
      ST_NAP:  if (!nap_req) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (nap_req) state_d = ST_NAP;
    last_ld = code_vld;
    base_ld = (state_q == ST_IDLE) && (state_d == ST_HEAT);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      last_q  <= CODE_ZERO;
      base_q  <= CODE_ZERO;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (last_ld)   last_q  <= code;
      if (base_ld)   base_q  <= base_in;
      if (fault_set) fault_q <= 1'b1;
    end
  end

  assign heat_en       = (state_q == ST_HEAT);
  assign ctl_state     = state_q;
  assign timeout_fault = fault_q;
  assign base_code     = base_q;

  // R9: nap forces the heater off at the next edge
  p_nap_heat_off_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    nap_req |=> !heat_en);

  // R5: fault flag never clears once set
  p_fault_sticky_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    timeout_fault |=> timeout_fault);

  // R7: saturated high code stops heating
  p_sat_stop_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (heat_en && code_vld && (code == CODE_SAT_HI)) |=> !heat_en);

  // R2: heating begins only after a request
  p_enter_on_req_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(heat_en) |-> $past(low_contrast));

  // R6: target limited to 14 and never below the baseline
  p_target_clamp_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (tgt <= CODE_CAP) && (tgt >= base_code || base_code == CODE_SAT_HI));
endmodule

// File: tb/test_heater_ctl.sv
`timescale 1ns/1ps
module test_heater_ctl;
  logic        clk;
  logic        rst_n;
  logic        code_vld;
  logic [3:0]  code;
  logic        low_contrast;
  logic        nap_req;
  logic [3:0]  cfg_step;
  logic [23:0] cfg_timeout;
  logic [7:0]  cfg_holdoff;
  logic        heat_en;
  logic [1:0]  ctl_state;
  logic        timeout_fault;
  logic [3:0]  base_code;

  heater_ctl i_heater_ctl (
    .clk(clk), .rst_n(rst_n), .code_vld(code_vld), .code(code),
    .low_contrast(low_contrast), .nap_req(nap_req), .cfg_step(cfg_step),
    .cfg_timeout(cfg_timeout), .cfg_holdoff(cfg_holdoff), .heat_en(heat_en),
    .ctl_state(ctl_state), .timeout_fault(timeout_fault), .base_code(base_code)
  );

  localparam logic [1:0] IDLE = 2'd0, HEAT = 2'd1, HOLD = 2'd2, NAP = 2'd3;

  typedef struct {
    logic       heat;
    logic [1:0] st;
    logic       flt;
    logic [3:0] base;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t e;
  int   total = 0;
  int   bad   = 0;
  logic exp_fault = 1'b0;
  logic [3:0] exp_base = 4'd8;
  bit   done = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // monitor: pops one expectation per edge after outputs settle
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      total++;
      if (heat_en !== e.heat || ctl_state !== e.st ||
          timeout_fault !== e.flt || base_code !== e.base) begin
        bad++;
        $display("FAIL %s: got heat=%0b st=%0d flt=%0b base=%0d exp heat=%0b st=%0d flt=%0b base=%0d",
                 e.tag, heat_en, ctl_state, timeout_fault, base_code,
                 e.heat, e.st, e.flt, e.base);
      end
    end
  end

  // driver: one cycle of stimulus plus the expected outputs after the edge
  task automatic cyc(input logic lc, input logic np, input logic vld,
                     input logic [3:0] cd, input logic [1:0] st, input string tag);
    exp_t x;
    @(negedge clk);
    low_contrast = lc;
    nap_req      = np;
    code_vld     = vld;
    code         = cd;
    x.heat = (st == HEAT);
    x.st   = st;
    x.flt  = exp_fault;
    x.base = exp_base;
    x.tag  = tag;
    exp_q.push_back(x);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; code_vld = 1'b0; code = 4'd0; low_contrast = 1'b0;
    nap_req = 1'b0; cfg_step = 4'd2; cfg_timeout = 24'd6; cfg_holdoff = 8'd2;
    repeat (4) @(negedge clk);
    total++;
    if (heat_en !== 1'b0 || ctl_state !== IDLE || timeout_fault !== 1'b0 || base_code !== 4'd8) begin
      bad++;
      $display("FAIL R1 reset: got heat=%0b st=%0d flt=%0b base=%0d exp 0 0 0 8",
               heat_en, ctl_state, timeout_fault, base_code);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3: exit on code reaching baseline+2
    cyc(0,0,1,4'd8, IDLE, "R1 idle after release");
    exp_base = 4'd8;
    cyc(1,0,0,4'd0, HEAT, "R2 enter heat held code");
    cyc(0,0,1,4'd9, HEAT, "R3 below target");
    cyc(0,0,1,4'd10, HOLD, "R3 target reached");
    cyc(1,0,0,4'd0, HOLD, "R8 request ignored");
    cyc(0,0,1,4'd10, HOLD, "R8 frame one");
    cyc(0,0,1,4'd10, HOLD, "R8 frame two");
    cyc(0,0,0,4'd0, IDLE, "R8 release, R5 no fault on code exit");

    // R4: timeout, cfg_timeout+1 cycles of heat
    exp_base = 4'd10;
    cyc(1,0,0,4'd0, HEAT, "R2 enter for timeout");
    for (int i = 0; i < 6; i++) cyc(0,0,i[0],4'd11, HEAT, "R4 still heating");
    exp_fault = 1'b1;
    cyc(0,0,0,4'd0, HOLD, "R4 timeout exit R5 fault");
    cyc(0,0,1,4'd11, HOLD, "R8 frame one");
    cyc(0,0,1,4'd11, HOLD, "R8 frame two");
    cyc(0,0,0,4'd0, IDLE, "R8 release");

    // R6: clamp at 14
    cyc(0,0,1,4'd13, IDLE, "R2 idle code");
    exp_base = 4'd13;
    cyc(1,0,0,4'd0, HEAT, "R2 enter base 13");
    cyc(0,0,1,4'd14, HOLD, "R6 clamped target 14");
    cyc(0,0,1,4'd14, HOLD, "R8 frame one");
    cyc(0,0,1,4'd14, HOLD, "R8 frame two");
    cyc(0,0,0,4'd0, IDLE, "R8 release");

    // R7: saturated code ends heating
    cfg_step = 4'd6;
    cyc(0,0,1,4'd8, IDLE, "R2 idle code");
    exp_base = 4'd8;
    cyc(1,0,0,4'd0, HEAT, "R2 enter step 6");
    cyc(0,0,1,4'd13, HEAT, "R7 below target");
    cyc(0,0,1,4'd15, HOLD, "R7 saturated stop");
    cyc(0,0,1,4'd15, HOLD, "R8 frame one");
    cyc(0,0,1,4'd15, HOLD, "R8 frame two");
    cyc(0,0,0,4'd0, IDLE, "R8 release");

    // R10: saturated baseline refused
    cyc(1,0,0,4'd0, IDLE, "R10 held code 15 refused");
    cyc(1,0,1,4'd15, IDLE, "R10 same-cycle 15 refused");
    cfg_step = 4'd2;
    exp_base = 4'd9;
    cyc(1,0,1,4'd9, HEAT, "R2 same-cycle baseline");

    // R9: nap
    cyc(0,1,0,4'd0, NAP, "R9 nap from heat");
    cyc(1,1,1,4'd3, NAP, "R9 nap held");
    cyc(0,0,0,4'd0, IDLE, "R9 nap left, R5 sticky");
    cyc(0,1,0,4'd0, NAP, "R9 nap from idle");
    cyc(0,0,0,4'd0, IDLE, "R9 back to idle");

    // R8: zero hold-off
    cfg_holdoff = 8'd0;
    exp_base = 4'd3;
    cyc(1,0,0,4'd0, HEAT, "R2 enter base 3");
    cyc(0,0,1,4'd4, HEAT, "R3 below target");
    cyc(0,0,1,4'd5, HOLD, "R3 target 5");
    cyc(0,0,0,4'd0, IDLE, "R8 zero hold-off");

    @(posedge clk);
    #2;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule